// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial bit stream whose frame layout is picked at run time. A 5-bit format word, captured on a one-cycle write strobe, sets the number of data bits (5 to 8), whether a parity bit is sent, which parity sense is used, and whether one or two stop bits close the frame. Bit timing comes from an external oversampling enable, `baud_tick`. Every serial bit lasts a fixed number of those enables, set by the parameter `OVERSAMPLE`.

Characters enter through a valid/ready port. A one-entry holding stage accepts a character whenever it is empty, so the next character can wait while the current one is on the line. Frames then follow each other with no idle gap. When the holding stage is full, `char_ready` is low. The source must keep `char_valid` and `char_data` steady until it sees a cycle with `char_ready` high. Nothing is captured while ready is low. Each character keeps the format that was in force on the cycle it was accepted. Two plain status pins show whether the holding stage is empty and whether the line has gone back to idle.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, `txd` is 1 and `hold_empty`, `line_idle` and `char_ready` are all 1.
- R2: A frame begins with exactly one low start bit. It continues with N data bits, least significant first. N comes from `cfg_word[4:3]`: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Bits of `char_data` above N are never sent.
- R3: When `cfg_word[2]` is 0, one parity bit follows the data bits. It is computed over the N data bits only. If `cfg_word[1]` is 1 (even), the total count of ones including the parity bit is even. If `cfg_word[1]` is 0 (odd), that count is odd. When `cfg_word[2]` is 1, no parity bit is sent.
- R4: The frame ends with high stop bits: one when `cfg_word[0]` is 0, two when it is 1. The line stays high while idle.
- R5: Every bit lasts exactly `OVERSAMPLE` cycles in which `baud_tick` is 1. Cycles with `baud_tick` at 0 leave `txd` unchanged.
- R6: `cfg_word` is captured on a cycle with `cfg_wr` high. A character uses the captured format that was current when it was accepted, even if the format is rewritten while the character waits.
- R7: A character is accepted on a clock edge where `char_valid` and `char_ready` are both 1. `char_ready` equals `hold_empty`. While the holding stage is full, a valid character is not captured and stays pending at the source. Every accepted character is sent exactly once, in order.
- R8: If a character is waiting when the last stop bit ends, its start bit begins on that same edge, so `line_idle` stays 0 between the two frames.
- R9: `line_idle` falls on the edge where the start bit begins. It rises when the last stop bit ends with no character waiting. After a character is accepted on an idle line, the next edge starts its frame and empties the holding stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling enable, OVERSAMPLE per bit |
| cfg_wr | input | 1 | Strobe that captures cfg_word |
| cfg_word | input | 5 | {length code[1:0], parity off, even parity, two stops} |
| char_valid | input | 1 | Source has a character |
| char_ready | output | 1 | Holding stage can take a character |
| char_data | input | 8 | Character, low N bits used |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding stage empty |
| line_idle | output | 1 | No frame on the line |

## Verification
The bench builds the block with `OVERSAMPLE` set to 4 and raises `baud_tick` on one cycle in three. This keeps a 12-bit frame under 150 cycles, and the gaps between enables show that bit timing follows the enable and not the clock. A second instance is not needed: all four length codes, both parity senses, no parity, and both stop counts fit in the table pass. The reduced oversampling also makes back-to-back frames, a format rewrite while a character waits, and a long enable stall cheap to reach.

// File: rtl/tx_fmt_pkg.sv
package tx_fmt_pkg;

  localparam int CHAR_W = 8;
  localparam int FMT_W  = 5;

  // Field order matches the format word: {len_code, par_off, par_even, two_stop}
  typedef struct packed {
    logic [1:0] len_code;
    logic       par_off;
    logic       par_even;
    logic       two_stop;
  } fmt_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } phase_t;

  function automatic logic [3:0] char_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

endpackage

// File: rtl/tx_cfg_latch.sv
module tx_cfg_latch
  import tx_fmt_pkg::*;
#(
  parameter logic [FMT_W-1:0] RESET_CFG = 5'b11100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [FMT_W-1:0] word,
  output fmt_t             fmt
);

  always_ff @(posedge clk) begin
    if (!rst_n)  fmt <= fmt_t'(RESET_CFG);
    else if (wr) fmt <= fmt_t'(word);
  end

endmodule

// File: rtl/tx_holding.sv
module tx_holding
  import tx_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  fmt_t              in_fmt,
  input  logic              pop,
  output logic              full,
  output logic [CHAR_W-1:0] out_data,
  output fmt_t              out_fmt
);

  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full     <= 1'b0;
      out_data <= '0;
      out_fmt  <= '0;
    end else if (in_valid && !full) begin
      full     <= 1'b1;
      out_data <= in_data;
      out_fmt  <= in_fmt;
    end else if (pop) begin
      full     <= 1'b0;
    end
  end

  // R7: a waiting character is neither replaced nor lost until the engine takes it
  a_r7_hold_keeps_char: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (full && $stable(out_data) && $stable(out_fmt)));

endmodule

// File: rtl/tx_frame_engine.sv
module tx_frame_engine
  import tx_fmt_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pend,
  input  logic [CHAR_W-1:0] pend_data,
  input  fmt_t              pend_fmt,
  output logic              take,
  output logic              txd,
  output logic              busy
);

  localparam int OCW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [OCW-1:0] OS_LAST = OCW'(OVS - 1);

  phase_t            phase;
  logic [CHAR_W-1:0] shreg;
  fmt_t              fmt_q;
  logic              par_acc;
  logic [3:0]        bits_left;
  logic              extra_stop;
  logic [OCW-1:0]    os_cnt;
  logic              bit_end;

  assign bit_end = tick && (os_cnt == OS_LAST);
  assign busy    = (phase != PH_IDLE);
  assign take    = pend && ((phase == PH_IDLE) ||
                   (phase == PH_STOP && bit_end && !extra_stop));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      txd        <= 1'b1;
      shreg      <= '0;
      fmt_q      <= '0;
      par_acc    <= 1'b0;
      bits_left  <= '0;
      extra_stop <= 1'b0;
      os_cnt     <= '0;
    end else begin
      if (tick && busy) os_cnt <= bit_end ? '0 : os_cnt + 1'b1;
      if (take) begin
        phase     <= PH_START;
        txd       <= 1'b0;
        shreg     <= pend_data;
        fmt_q     <= pend_fmt;
        bits_left <= char_bits(pend_fmt.len_code);
        par_acc   <= 1'b0;
        os_cnt    <= '0;
      end else if (bit_end) begin
        case (phase)
          PH_START: begin
            phase     <= PH_DATA;
            txd       <= shreg[0];
            par_acc   <= shreg[0];
            shreg     <= shreg >> 1;
            bits_left <= bits_left - 1'b1;
          end
          PH_DATA: begin
            if (bits_left != '0) begin
              txd       <= shreg[0];
              par_acc   <= par_acc ^ shreg[0];
              shreg     <= shreg >> 1;
              bits_left <= bits_left - 1'b1;
            end else if (!fmt_q.par_off) begin
              phase <= PH_PARITY;
              txd   <= fmt_q.par_even ? par_acc : ~par_acc;
            end else begin
              phase      <= PH_STOP;
              txd        <= 1'b1;
              extra_stop <= fmt_q.two_stop;
            end
          end
          PH_PARITY: begin
            phase      <= PH_STOP;
            txd        <= 1'b1;
            extra_stop <= fmt_q.two_stop;
          end
          PH_STOP: begin
            if (extra_stop) extra_stop <= 1'b0;
            else begin
              phase <= PH_IDLE;
              txd   <= 1'b1;
            end
          end
          default: begin
            phase <= PH_IDLE;
            txd   <= 1'b1;
          end
        endcase
      end
    end
  end

  // R1: idle line is high
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R2: a frame opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  // R4: stop bits are high
  a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STOP) |-> txd);
  // R5: without an enable the line does not move
  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> ($stable(txd) && $stable(phase)));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import tx_fmt_pkg::*;
#(
  parameter int                OVERSAMPLE = 16,
  parameter logic [FMT_W-1:0]  RESET_CFG  = 5'b11100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              cfg_wr,
  input  logic [FMT_W-1:0]  cfg_word,
  input  logic              char_valid,
  output logic              char_ready,
  input  logic [CHAR_W-1:0] char_data,
  output logic              txd,
  output logic              hold_empty,
  output logic              line_idle
);

  fmt_t              cur_fmt;
  fmt_t              wait_fmt;
  logic [CHAR_W-1:0] wait_data;
  logic              wait_full;
  logic              take;
  logic              busy;

  tx_cfg_latch #(.RESET_CFG(RESET_CFG)) u_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (cfg_wr),
    .word (cfg_word),
    .fmt  (cur_fmt)
  );

  tx_holding u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(char_valid),
    .in_ready(char_ready),
    .in_data (char_data),
    .in_fmt  (cur_fmt),
    .pop     (take),
    .full    (wait_full),
    .out_data(wait_data),
    .out_fmt (wait_fmt)
  );

  tx_frame_engine #(.OVS(OVERSAMPLE)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .pend     (wait_full),
    .pend_data(wait_data),
    .pend_fmt (wait_fmt),
    .take     (take),
    .txd      (txd),
    .busy     (busy)
  );

  assign hold_empty = !wait_full;
  assign line_idle  = !busy;

  // R9: a waiting character on an idle line starts its frame on the next edge
  a_r9_idle_starts_next: assert property (@(posedge clk) disable iff (!rst_n)
    (line_idle && !hold_empty) |=> (!line_idle && hold_empty));

endmodule

// File: tb/test_serial_frame_tx.sv
`timescale 1ns/1ps
module test_serial_frame_tx;

  localparam int OVS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [4:0] cfg_word = '0;
  logic       char_valid = 1'b0;
  logic       char_ready;
  logic [7:0] char_data = '0;
  logic       txd, hold_empty, line_idle;

  always #4 clk = ~clk;

  serial_frame_tx #(.OVERSAMPLE(OVS)) i_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .char_valid(char_valid), .char_ready(char_ready), .char_data(char_data),
    .txd(txd), .hold_empty(hold_empty), .line_idle(line_idle)
  );

  // {cfg = len_code[1:0], parity_off, even, two_stop ; data}
  localparam logic [12:0] VEC [0:7] = '{
    {5'b00010, 8'hA5}, {5'b01001, 8'h3C}, {5'b10100, 8'h5A}, {5'b11011, 8'h96},
    {5'b11100, 8'hFF}, {5'b00101, 8'hE3}, {5'b01010, 8'h81}, {5'b10001, 8'h00}
  };

  int n_chk = 0, n_bad = 0;
  int frames_done = 0;
  int idle_cnt = 0;
  bit count_idle = 0;
  bit tick_en = 1;
  int cyc = 0;
  logic [4:0] cfg_sh = 5'b11100;

  logic [11:0] q_bits [0:31];
  int          q_len  [0:31];
  int          q_wp = 0, q_rp = 0;

  function automatic int frame_len(input logic [4:0] c);
    return 1 + 5 + int'(c[4:3]) + (c[2] ? 0 : 1) + (c[0] ? 2 : 1);
  endfunction

  function automatic logic [11:0] frame_bits(input logic [4:0] c, input logic [7:0] d);
    logic [11:0] b;
    int n, k;
    logic p;
    b = '1;
    n = 5 + int'(c[4:3]);
    b[0] = 1'b0;
    k = 1;
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      b[k] = d[i];
      p = p ^ d[i];
      k++;
    end
    if (!c[2]) b[k] = c[1] ? p : ~p;
    return b;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  // monitor and tick generator share one negedge process
  bit          mon_on = 0;
  int          tcount = 0, bidx = 0, clen = 0;
  logic [11:0] got_b, exp_b;

  always @(negedge clk) begin
    cyc++;
    if (count_idle && line_idle) idle_cnt++;
    if (rst_n) begin
      if (!mon_on) begin
        if (txd == 1'b0) begin
          mon_on = 1; tcount = 0; bidx = 0; got_b = '1;
          if (q_rp == q_wp) begin
            clen = 1; exp_b = '1;
          end else begin
            exp_b = q_bits[q_rp[4:0]];
            clen  = q_len[q_rp[4:0]];
            q_rp++;
          end
        end
      end else if (baud_tick) begin
        tcount++;
        if (tcount == bidx * OVS + OVS / 2) begin
          got_b[bidx] = txd;
          bidx++;
          if (bidx == clen) begin
            // R2 R3 R4 R5: whole frame seen at bit centres
            chk(got_b == exp_b, "R2 R3 R4 R5 frame bits", 32'(got_b), 32'(exp_b));
            frames_done++;
            mon_on = 0;
          end
        end
      end
    end
    baud_tick = tick_en && (cyc % 3 == 0);
  end

  task automatic write_cfg(input logic [4:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_word = w;
    @(negedge clk);
    cfg_wr = 1'b0;
    cfg_sh = w;
  endtask

  // returns at the negedge right after acceptance
  task automatic push(input logic [7:0] d);
    @(negedge clk);
    char_valid = 1'b1; char_data = d;
    while (!char_ready) @(negedge clk);
    @(negedge clk);
    char_valid = 1'b0;
    q_bits[q_wp[4:0]] = frame_bits(cfg_sh, d);
    q_len[q_wp[4:0]]  = frame_len(cfg_sh);
    q_wp++;
  endtask

  task automatic wait_frames(input int target);
    while (frames_done < target) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(line_idle && hold_empty)) @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1,       "R1 txd after reset", 32'(txd), 1);
    chk(hold_empty == 1'b1, "R1 hold_empty after reset", 32'(hold_empty), 1);
    chk(line_idle == 1'b1,  "R1 line_idle after reset", 32'(line_idle), 1);
    chk(char_ready == 1'b1, "R1 char_ready after reset", 32'(char_ready), 1);

    // table pass: every format, one frame each (R2 R3 R4 R6)
    for (int i = 0; i < 8; i++) begin
      write_cfg(VEC[i][12:8]);
      push(VEC[i][7:0]);
      wait_frames(i + 1);
      wait_idle();
    end

    // R7 R9: status right after accept on an idle line, then the next edge
    write_cfg(5'b11010);
    push(8'h6E);
    chk(hold_empty == 1'b0, "R7 hold_empty after accept", 32'(hold_empty), 0);
    chk(char_ready == 1'b0, "R7 char_ready after accept", 32'(char_ready), 0);
    chk(line_idle == 1'b1,  "R9 line_idle before start", 32'(line_idle), 1);
    @(negedge clk);
    chk(hold_empty == 1'b1, "R9 holding empties on start", 32'(hold_empty), 1);
    chk(line_idle == 1'b0,  "R9 line_idle falls on start", 32'(line_idle), 0);
    chk(txd == 1'b0,        "R2 start bit low", 32'(txd), 0);

    // R5 stall: no enables, line frozen
    repeat (10) @(negedge clk);
    tick_en = 0;
    repeat (2) @(negedge clk);
    begin
      logic held;
      bit   steady;
      held = txd; steady = 1;
      repeat (30) begin
        @(negedge clk);
        if (txd !== held) steady = 0;
      end
      chk(steady, "R5 txd steady without enables", 32'(txd), 32'(held));
    end
    tick_en = 1;
    wait_frames(9);
    wait_idle();

    // R6 R7 R8: back-to-back, format rewrite while waiting, back-pressure
    write_cfg(5'b00001);
    push(8'h15);                 // A with format 00001
    write_cfg(5'b11000);
    @(negedge clk);
    idle_cnt = 0; count_idle = 1;
    push(8'hC3);                 // B waits with format 11000
    write_cfg(5'b10110);         // rewrite while B waits
    @(negedge clk);
    char_valid = 1'b1; char_data = 8'h2B;
    repeat (5) @(negedge clk);
    chk(char_ready == 1'b0, "R7 ready low while holding full", 32'(char_ready), 0);
    chk(hold_empty == 1'b0, "R7 holding still full", 32'(hold_empty), 0);
    char_valid = 1'b0;
    push(8'h2B);                 // C with format 10110
    wait_frames(12);
    count_idle = 0;
    chk(idle_cnt == 0, "R8 no idle gap between queued frames", 32'(idle_cnt), 0);
    wait_idle();
    chk(q_rp == q_wp, "R7 every accepted character sent once", 32'(q_rp), 32'(q_wp));
    chk(frames_done == 12, "R7 frame count", 32'(frames_done), 12);

    // R4 R9: back at idle
    repeat (3) @(negedge clk);
    chk(txd == 1'b1,       "R4 line high at idle", 32'(txd), 1);
    chk(line_idle == 1'b1, "R9 line_idle after last stop", 32'(line_idle), 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule